// File: doc/BRIEF.md
# Multi-Section Tapped Shift Register

This block holds eighteen flip-flop stages split into four serial shift-register sections. The sections share one clock and nothing else. Two sections are four stages long. The other two are five stages long, and each also brings out the value held in its fourth stage. Every section takes one serial data bit. On each falling clock edge, that bit enters the section and everything already stored moves one stage further along.

The first section has a second copy of its final output. This copy follows the main output half a clock period later, because it is captured on the rising edge. A downstream register fed from it therefore sees a value that stays stable around the next falling edge, even when the clock edges are slow. Storage is fully static: the contents stay put for as long as the clock is stopped, whether it rests high or low.

Users wire one section's output into another section's input to build longer registers. The four lengths can be combined into 4, 5, 8, 9, 10, 12, 13, 14, 16, 17 or 18 stages. A synchronous active-high clear, sampled on the falling edge, empties every stage. The clear also reaches the delayed copy on the rising edge.

Top module: `quad_shift_bank`

## Requirements
- R1: A bit presented on `ser_a` before a falling edge appears on `q_a` right after the fourth falling edge that counts that one as the first.
- R2: A bit presented on `ser_b` appears on `q_b` after the fourth falling edge in the same way.
- R3: A bit presented on `ser_c` appears on `tap_c` after the fourth falling edge and on `q_c` after the fifth.
- R4: A bit presented on `ser_d` appears on `tap_d` after the fourth falling edge and on `q_d` after the fifth.
- R5: A rising clock edge never changes `q_a`, `q_b`, `q_c`, `q_d`, `tap_c` or `tap_d`.
- R6: `q_a_lag` takes the value of `q_a` at each rising edge, so after any rising edge it equals the value `q_a` took at the falling edge just before.
- R7: When `clr` is 1 at a falling edge, every stage becomes 0 whatever the serial inputs are. When `clr` is 1 at a rising edge, `q_a_lag` becomes 0. The clear has priority over shifting.
- R8: While the clock is held steady, either high or low, all outputs keep their values no matter how the serial inputs change.
- R9: The sections do not interact: activity on one serial input never changes another section's outputs.
- R10: When wired externally as `q_a`→`ser_b`, `q_b`→`ser_c` and `q_c`→`ser_d`, a bit entering `ser_a` reaches `q_d` after the eighteenth falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; stages shift on the falling edge |
| clr | input | 1 | Synchronous clear, active high |
| ser_a | input | 1 | Serial input of the first four-stage section |
| ser_b | input | 1 | Serial input of the second four-stage section |
| ser_c | input | 1 | Serial input of the first five-stage section |
| ser_d | input | 1 | Serial input of the second five-stage section |
| q_a | output | 1 | Last stage of the first four-stage section |
| q_a_lag | output | 1 | `q_a` captured on the rising edge (half period later) |
| q_b | output | 1 | Last stage of the second four-stage section |
| q_c | output | 1 | Fifth stage of the first five-stage section |
| tap_c | output | 1 | Fourth stage of the first five-stage section |
| q_d | output | 1 | Fifth stage of the second five-stage section |
| tap_d | output | 1 | Fourth stage of the second five-stage section |

## Verification
Each bit enters at a falling edge. The four-stage outputs and both taps show it three falling edges after that. The five-stage outputs show it four edges after that. The chained eighteen-stage output shows it seventeen edges after that. The delayed copy follows at the next rising edge. The bench keeps one queue per output, preloaded with one zero for each of those pending edges. It pushes each bit when it drives the inputs, two time units after a rising edge. It pops and compares exactly one entry two time units after every falling edge, and two units after the next rising edge it compares the delayed copy against the value just popped for the first section. At those rising-edge checks it also confirms that the main outputs have not moved since the falling edge before.

// File: rtl/qsb_pkg.sv
package qsb_pkg;

   localparam int unsigned QSB_SECTIONS   = 4;
   localparam int unsigned QSB_SHORT_DEF  = 4;
   localparam int unsigned QSB_LONG_DEF   = 5;

   // Sections 0 and 1 are the short ones, 2 and 3 the long ones.
   function automatic int unsigned qsb_len(input int idx,
                                           input int unsigned short_len,
                                           input int unsigned long_len);
      return (idx < 2) ? short_len : long_len;
   endfunction

   function automatic int unsigned qsb_total(input int unsigned short_len,
                                             input int unsigned long_len);
      return 2 * short_len + 2 * long_len;
   endfunction

endpackage

// File: rtl/qsb_section.sv
module qsb_section #(
   parameter  int unsigned LEN     = 4,
   parameter  int unsigned TAP_POS = 0,
   localparam int unsigned NOUT    = (TAP_POS == 0) ? 1 : 2
) (
   input  logic            clk,
   input  logic            clr,
   input  logic            din,
   output logic [NOUT-1:0] outs
);

   if (LEN < 2) begin : g_bad_len
      $error("qsb_section: LEN must be at least 2");
   end
   if (TAP_POS >= LEN) begin : g_bad_tap
      $error("qsb_section: TAP_POS must lie below LEN");
   end

   logic [LEN-1:0] stg;

   always_ff @(negedge clk) begin
      if (clr) stg <= '0;
      else     stg <= {stg[LEN-2:0], din};
   end

   assign outs[0] = stg[LEN-1];

   if (TAP_POS != 0) begin : g_tap
      assign outs[NOUT-1] = stg[TAP_POS-1];
   end

   // Tracks how many clean falling edges have passed since a clear.
   logic [1:0] armed_q;
   always_ff @(negedge clk) begin
      if (clr)                  armed_q <= 2'b01;
      else if (armed_q != 2'b00) armed_q <= 2'b11;
   end

   AST_CLEAR_EMPTIES: assert property (@(negedge clk) disable iff (armed_q == 2'b00)
      clr |=> (outs == '0)); // R7

   if (TAP_POS != 0 && TAP_POS == LEN - 1) begin : g_tap_chk
      AST_TAP_FEEDS_END: assert property (@(negedge clk) disable iff (clr || armed_q != 2'b11)
         outs[0] == $past(outs[NOUT-1])); // R3
   end

endmodule

// File: rtl/qsb_half_lag.sv
module qsb_half_lag #(
   parameter bit CLEAR_ON_RISE = 1'b1
) (
   input  logic clk,
   input  logic clr,
   input  logic src,
   output logic lag
);

   if (CLEAR_ON_RISE) begin : g_clr
      always_ff @(posedge clk) begin
         if (clr) lag <= 1'b0;
         else     lag <= src;
      end
   end else begin : g_plain
      always_ff @(posedge clk) lag <= src;
   end

   logic [1:0] armed_q;
   always_ff @(negedge clk) begin
      if (clr)                  armed_q <= 2'b01;
      else if (armed_q != 2'b00) armed_q <= 2'b11;
   end

   AST_LAG_TRACKS: assert property (@(negedge clk) disable iff (clr || armed_q != 2'b11)
      lag == src); // R6

   if (CLEAR_ON_RISE) begin : g_clr_chk
      AST_LAG_CLEAR: assert property (@(posedge clk) disable iff (armed_q == 2'b00)
         clr |=> (lag == 1'b0)); // R7
   end

endmodule

// File: rtl/quad_shift_bank.sv
module quad_shift_bank
   import qsb_pkg::*;
#(
   parameter int unsigned SHORT_LEN = QSB_SHORT_DEF,
   parameter int unsigned LONG_LEN  = QSB_LONG_DEF,
   parameter int unsigned TAP_AFTER = 4,
   parameter bit          LAG_CLEAR = 1'b1
) (
   input  logic clk,
   input  logic clr,
   input  logic ser_a,
   input  logic ser_b,
   input  logic ser_c,
   input  logic ser_d,
   output logic q_a,
   output logic q_a_lag,
   output logic q_b,
   output logic q_c,
   output logic tap_c,
   output logic q_d,
   output logic tap_d
);

   localparam int unsigned TOTAL = qsb_total(SHORT_LEN, LONG_LEN);

   if (SHORT_LEN < 2 || LONG_LEN < 2) begin : g_bad_len
      $error("quad_shift_bank: section lengths must be at least 2");
   end
   if (TAP_AFTER == 0 || TAP_AFTER >= LONG_LEN) begin : g_bad_tap
      $error("quad_shift_bank: TAP_AFTER must lie between 1 and LONG_LEN-1");
   end
   if (TOTAL != SHORT_LEN * 2 + LONG_LEN * 2) begin : g_bad_total
      $error("quad_shift_bank: stage total mismatch");
   end

   logic [QSB_SECTIONS-1:0] din_v;
   logic [QSB_SECTIONS-1:0] last_v;
   logic [1:0]              tap_v;

   assign din_v = {ser_d, ser_c, ser_b, ser_a};

   for (genvar i = 0; i < QSB_SECTIONS; i++) begin : g_sec
      localparam int unsigned SLEN = qsb_len(i, SHORT_LEN, LONG_LEN);
      if (i < 2) begin : g_plain
         qsb_section #(.LEN(SLEN), .TAP_POS(0)) u_sec (
            .clk  (clk),
            .clr  (clr),
            .din  (din_v[i]),
            .outs (last_v[i])
         );
      end else begin : g_tapped
         logic [1:0] o;
         qsb_section #(.LEN(SLEN), .TAP_POS(TAP_AFTER)) u_sec (
            .clk  (clk),
            .clr  (clr),
            .din  (din_v[i]),
            .outs (o)
         );
         assign last_v[i]   = o[0];
         assign tap_v[i-2]  = o[1];
      end
   end

   qsb_half_lag #(.CLEAR_ON_RISE(LAG_CLEAR)) u_lag (
      .clk (clk),
      .clr (clr),
      .src (last_v[0]),
      .lag (q_a_lag)
   );

   assign q_a   = last_v[0];
   assign q_b   = last_v[1];
   assign q_c   = last_v[2];
   assign q_d   = last_v[3];
   assign tap_c = tap_v[0];
   assign tap_d = tap_v[1];

endmodule

// File: tb/quad_shift_bank_test.sv
module quad_shift_bank_test;

   localparam int PERIOD = 10;
   localparam int SHORT  = 4;
   localparam int LONG   = 5;
   localparam int TAPL   = 4;
   localparam int CHAIN  = 2 * SHORT + 2 * LONG;

   logic clk = 1'b1;
   logic run = 1'b1;
   logic clr, chain, track, have_snap;
   logic a_in, b_drv, c_drv, d_drv;
   logic ser_a, ser_b, ser_c, ser_d;
   logic q_a, q_a_lag, q_b, q_c, tap_c, q_d, tap_d;
   logic exp_lag;
   logic [5:0] snap;
   int n_chk = 0;
   int n_err = 0;

   logic qa[$], qb[$], qc[$], qct[$], qd[$], qdt[$], q18[$];

   assign ser_a = a_in;
   assign ser_b = chain ? q_a : b_drv;
   assign ser_c = chain ? q_b : c_drv;
   assign ser_d = chain ? q_c : d_drv;

   quad_shift_bank uut (
      .clk(clk), .clr(clr),
      .ser_a(ser_a), .ser_b(ser_b), .ser_c(ser_c), .ser_d(ser_d),
      .q_a(q_a), .q_a_lag(q_a_lag), .q_b(q_b), .q_c(q_c),
      .tap_c(tap_c), .q_d(q_d), .tap_d(tap_d)
   );

   initial forever begin
      #(PERIOD/2);
      if (run) clk = ~clk;
   end

   task automatic chk(input logic got, input logic exp, input string tag);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
      end
   endtask

   // Monitor on falling edges: pop one expected entry per output.
   always @(negedge clk) begin
      if (track) begin
         logic ea, eb, ec, ect, ed, edt, e18;
         #2;
         ea  = qa.pop_front();  eb  = qb.pop_front();
         ec  = qc.pop_front();  ect = qct.pop_front();
         ed  = qd.pop_front();  edt = qdt.pop_front();
         e18 = q18.pop_front();
         chk(q_a, ea, "R1 q_a");
         if (!chain) begin
            chk(q_b, eb, "R2 q_b");
            chk(tap_c, ect, "R3 tap_c");
            chk(q_c, ec, "R3 q_c");
            chk(tap_d, edt, "R4 tap_d");
            chk(q_d, ed, "R4 q_d");
         end else begin
            chk(q_d, e18, "R10 chained q_d");
         end
         exp_lag   = ea;
         snap      = {q_a, q_b, q_c, tap_c, q_d, tap_d};
         have_snap = 1'b1;
      end
   end

   // Monitor on rising edges: delayed copy and no movement of main outputs.
   always @(posedge clk) begin
      if (track && have_snap) begin
         #2;
         chk(q_a_lag, exp_lag, "R6 q_a_lag");
         chk(q_a,   snap[5], "R5 q_a");
         chk(q_b,   snap[4], "R5 q_b");
         chk(q_c,   snap[3], "R5 q_c");
         chk(tap_c, snap[2], "R5 tap_c");
         chk(q_d,   snap[1], "R5 q_d");
         chk(tap_d, snap[0], "R5 tap_d");
      end
   end

   task automatic reinit();
      qa.delete(); qb.delete(); qc.delete(); qct.delete();
      qd.delete(); qdt.delete(); q18.delete();
      for (int k = 0; k < SHORT - 1; k++) begin qa.push_back(1'b0); qb.push_back(1'b0); end
      for (int k = 0; k < TAPL - 1; k++)  begin qct.push_back(1'b0); qdt.push_back(1'b0); end
      for (int k = 0; k < LONG - 1; k++)  begin qc.push_back(1'b0); qd.push_back(1'b0); end
      for (int k = 0; k < CHAIN - 1; k++) q18.push_back(1'b0);
      exp_lag   = 1'b0;
      have_snap = 1'b0;
   endtask

   // Driver: called at rising edge + 2, returns at the next rising edge + 2.
   task automatic step(input logic a, input logic b, input logic c, input logic d);
      a_in = a; b_drv = b; c_drv = c; d_drv = d;
      qa.push_back(a); qb.push_back(b); qc.push_back(c); qct.push_back(c);
      qd.push_back(d); qdt.push_back(d); q18.push_back(a);
      @(posedge clk); #2;
   endtask

   task automatic check_all_zero(input string tag);
      chk(q_a, 1'b0, tag); chk(q_b, 1'b0, tag); chk(q_c, 1'b0, tag);
      chk(tap_c, 1'b0, tag); chk(q_d, 1'b0, tag); chk(tap_d, 1'b0, tag);
   endtask

   task automatic clear_all(input logic next_chain);
      track = 1'b0;
      clr = 1'b1;
      a_in = 1'b1; b_drv = 1'b1; c_drv = 1'b1; d_drv = 1'b1;
      @(negedge clk); #2;
      check_all_zero("R7 clear stages");
      @(posedge clk); #2;
      chk(q_a_lag, 1'b0, "R7 clear lag");
      clr = 1'b0;
      chain = next_chain;
      reinit();
      track = 1'b1;
   endtask

   task automatic compare_held(input logic [6:0] s, input string tag);
      chk(q_a, s[6], tag); chk(q_b, s[5], tag); chk(q_c, s[4], tag);
      chk(tap_c, s[3], tag); chk(q_d, s[2], tag); chk(tap_d, s[1], tag);
      chk(q_a_lag, s[0], tag);
   endtask

   // Clock parked high: entered at rising edge + 2.
   task automatic hold_high(input logic a, input logic b, input logic c, input logic d);
      logic [6:0] s;
      run = 1'b0;
      s = {q_a, q_b, q_c, tap_c, q_d, tap_d, q_a_lag};
      a_in = ~a_in; b_drv = ~b_drv; c_drv = ~c_drv; d_drv = ~d_drv;
      #(PERIOD*2);
      a_in = ~a_in; b_drv = ~b_drv; c_drv = ~c_drv; d_drv = ~d_drv;
      #(PERIOD*3);
      compare_held(s, "R8 held high");
      a_in = a; b_drv = b; c_drv = c; d_drv = d;
      qa.push_back(a); qb.push_back(b); qc.push_back(c); qct.push_back(c);
      qd.push_back(d); qdt.push_back(d); q18.push_back(a);
      run = 1'b1;
      @(posedge clk); #2;
   endtask

   // Clock parked low after a falling edge.
   task automatic hold_low(input logic a, input logic b, input logic c, input logic d);
      logic [6:0] s;
      a_in = a; b_drv = b; c_drv = c; d_drv = d;
      qa.push_back(a); qb.push_back(b); qc.push_back(c); qct.push_back(c);
      qd.push_back(d); qdt.push_back(d); q18.push_back(a);
      @(negedge clk); #3;
      run = 1'b0;
      s = {q_a, q_b, q_c, tap_c, q_d, tap_d, q_a_lag};
      a_in = ~a_in; b_drv = ~b_drv; c_drv = ~c_drv; d_drv = ~d_drv;
      #(PERIOD*5);
      compare_held(s, "R8 held low");
      run = 1'b1;
      @(posedge clk); #2;
   endtask

   function automatic logic [15:0] lfsr_nx(input logic [15:0] v);
      return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
   endfunction

   initial begin
      #(PERIOD * 100000);
      n_err++;
      $display("FAIL watchdog R10: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [15:0] lf;
      lf = 16'hACE1;
      clr = 1'b1; chain = 1'b0; track = 1'b0; have_snap = 1'b0; exp_lag = 1'b0;
      a_in = 1'b0; b_drv = 1'b0; c_drv = 1'b0; d_drv = 1'b0;
      repeat (3) @(negedge clk);
      @(posedge clk); #2;
      check_all_zero("R7 reset state");
      chk(q_a_lag, 1'b0, "R7 reset lag");
      clr = 1'b0;
      reinit();
      track = 1'b1;

      // Walking one into the first section only; others must stay quiet (R9).
      step(1'b1, 1'b0, 1'b0, 1'b0);
      for (int k = 0; k < 7; k++) begin
         step(1'b0, 1'b0, 1'b0, 1'b0);
         chk(q_b, 1'b0, "R9 q_b quiet");
         chk(q_c, 1'b0, "R9 q_c quiet");
         chk(q_d, 1'b0, "R9 q_d quiet");
      end

      // Single one into each long section to show tap then end.
      step(1'b0, 1'b1, 1'b1, 1'b0);
      for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 1'b0, 1'b1);
      for (int k = 0; k < 6; k++) step(1'b0, 1'b0, 1'b0, 1'b0);

      // Independent pseudo-random streams.
      for (int k = 0; k < 40; k++) begin
         lf = lfsr_nx(lf);
         step(lf[0], lf[3], lf[7], lf[11]);
      end

      // Alternating pattern drives the delayed copy hard.
      for (int k = 0; k < 12; k++) step(k[0], ~k[0], k[1], ~k[1]);

      // Static storage with the clock stopped.
      hold_high(1'b1, 1'b0, 1'b1, 1'b1);
      for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b0, 1'b1);
      hold_low(1'b0, 1'b1, 1'b1, 1'b0);
      for (int k = 0; k < 6; k++) begin
         lf = lfsr_nx(lf);
         step(lf[1], lf[4], lf[8], lf[12]);
      end

      // Clear in the middle of a stream of ones.
      for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 1'b1, 1'b1);
      clear_all(1'b0);
      for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 1'b1, 1'b0);

      // Eighteen-stage chain through external wiring.
      clear_all(1'b1);
      step(1'b1, 1'b0, 1'b0, 1'b0);
      for (int k = 0; k < 20; k++) step(1'b0, 1'b0, 1'b0, 1'b0);
      for (int k = 0; k < 60; k++) begin
         lf = lfsr_nx(lf);
         step(lf[2], 1'b0, 1'b0, 1'b0);
      end
      clear_all(1'b0);
      for (int k = 0; k < 6; k++) step(1'b0, 1'b1, 1'b0, 1'b1);

      track = 1'b0;
      @(posedge clk); #2;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule